// File: doc/BRIEF.md
# Polled Console Register Block

This block places a keyboard and a character display on a 16-bit processor bus as four fixed locations: keyboard status, keyboard data, display status and display data. Software uses plain loads and stores to reach them. There is no dedicated I/O instruction. A program spins on a status word until its top bit says the device is ready, then moves one character through the matching data word.

The keyboard side accepts characters from a source over a valid/ready handshake. It holds one character at a time and refuses the next until software has read the current one. The display side takes a character from a store and presents it to a sink over a valid/ready handshake. It then withholds its ready flag until the sink has taken that character.

Each status word also carries a software-owned interrupt-enable flag. The block only stores this flag and returns it on reads. Address decode and read data are combinational, so read data belongs to the same cycle as the read strobe.

The keyboard port is a two-state machine:
- KB_EMPTY moves to KB_FULL on a source handshake.
- KB_FULL moves to KB_EMPTY on a read of keyboard data.

The display port is also a two-state machine:
- DSP_IDLE moves to DSP_SEND on a store to display data.
- DSP_SEND moves to DSP_IDLE on a sink handshake.

Top module: `con_io_regs`

## Requirements
- R1: A read of 0xFE00 returns bit 15 = keyboard character held, bit 14 = keyboard interrupt enable, and bits 13..0 = 0.
- R2: In KB_EMPTY, `kbd_ready` is 1. A cycle with `kbd_valid` and `kbd_ready` both high latches `kbd_char` and enters KB_FULL. In KB_FULL, `kbd_ready` is 0 and offered characters are not taken.
- R3: A read of 0xFE02 returns {8'h00, held character} in the same cycle. If the port is in KB_FULL, the read returns it to KB_EMPTY, so status bit 15 reads 0 and `kbd_ready` is 1 from the next cycle.
- R4: A read of 0xFE04 returns bit 15 = display ready (1 in DSP_IDLE), bit 14 = display interrupt enable, and bits 13..0 = 0.
- R5: A store to 0xFE06 in DSP_IDLE captures bits 7..0 of the write data and enters DSP_SEND. From the next cycle, `dsp_valid` is 1 with that character on `dsp_char`, and a read of 0xFE06 returns {8'h00, character}.
- R6: In DSP_SEND, `dsp_valid` and `dsp_char` hold steady until `dsp_ready` is 1. In the cycle after that handshake, `dsp_valid` is 0 and display status bit 15 reads 1.
- R7: A store to 0xFE06 in DSP_SEND is dropped. Neither the character in flight nor the state changes.
- R8: A store to 0xFE00 or 0xFE04 sets that device's interrupt enable from write-data bit 14. Write-data bit 15 has no effect on the ready bits.
- R9: When no read to one of the four addresses is made, `bus_rdata` is 0. Accesses to any other address change no state.
- R10: After reset, keyboard status reads 0x0000, keyboard data reads 0x0000, display status reads 0x8000, `dsp_valid` is 0 and `kbd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_rd` |
| kbd_valid | input | 1 | Keyboard source offers a character |
| kbd_char | input | 8 | Offered character |
| kbd_ready | output | 1 | Block can take a character |
| dsp_valid | output | 1 | Character presented to display sink |
| dsp_char | output | 8 | Presented character |
| dsp_ready | input | 1 | Sink takes the character |

## Verification
The bench checks that a keyboard character offered while one is already held is not taken. A design that overwrote the held character would hand software the second character instead of the first.

It stores to display data while a character is still in flight. A design that accepted that store would change `dsp_char` in mid-handshake or send an extra character.

It confirms that display ready returns exactly one cycle after the sink handshake and not before. It also writes status words with bit 15 set, to catch a design that lets software force the ready bits.

Its reads of other addresses and of bus-idle cycles catch a decoder that aliases the partial address or leaks stale read data.

// File: rtl/con_pkg.sv
package con_pkg;
    typedef enum logic [0:0] {
        KB_EMPTY = 1'b0,
        KB_FULL  = 1'b1
    } kb_state_t;

    typedef enum logic [0:0] {
        DSP_IDLE = 1'b0,
        DSP_SEND = 1'b1
    } dsp_state_t;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_KSTAT = 3'd1,
        SEL_KDATA = 3'd2,
        SEL_DSTAT = 3'd3,
        SEL_DDATA = 3'd4
    } reg_sel_t;
endpackage

// File: rtl/con_addr_dec.sv
module con_addr_dec
    import con_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        if (addr == ADDR_W'(KSTAT_ADDR))      sel = SEL_KSTAT;
        else if (addr == ADDR_W'(KDATA_ADDR)) sel = SEL_KDATA;
        else if (addr == ADDR_W'(DSTAT_ADDR)) sel = SEL_DSTAT;
        else if (addr == ADDR_W'(DDATA_ADDR)) sel = SEL_DDATA;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/con_kbd_port.sv
module con_kbd_port
    import con_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_char,
    output logic              src_ready,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              ie_in,
    output logic              full,
    output logic              ie,
    output logic [CHAR_W-1:0] char_q
);
    kb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KB_EMPTY: if (src_valid) state_d = KB_FULL;
            KB_FULL:  if (data_rd)   state_d = KB_EMPTY;
            default:                 state_d = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KB_EMPTY;
            char_q  <= '0;
            ie      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == KB_EMPTY && src_valid) char_q <= src_char;
            if (stat_wr) ie <= ie_in;
        end
    end

    always_comb begin
        src_ready = 1'b0;
        full      = 1'b0;
        unique case (state_q)
            KB_EMPTY: src_ready = 1'b1;
            KB_FULL:  full      = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/con_dsp_port.sv
module con_dsp_port
    import con_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              stat_wr,
    input  logic              ie_in,
    output logic              sink_valid,
    output logic [CHAR_W-1:0] sink_char,
    input  logic              sink_ready,
    output logic              rdy,
    output logic              ie
);
    dsp_state_t state_q, state_d;
    logic [CHAR_W-1:0] char_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DSP_IDLE: if (data_wr)    state_d = DSP_SEND;
            DSP_SEND: if (sink_ready) state_d = DSP_IDLE;
            default:                  state_d = DSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DSP_IDLE;
            char_q  <= '0;
            ie      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == DSP_IDLE && data_wr) char_q <= wr_char;
            if (stat_wr) ie <= ie_in;
        end
    end

    always_comb begin
        sink_valid = 1'b0;
        rdy        = 1'b0;
        unique case (state_q)
            DSP_IDLE: rdy        = 1'b1;
            DSP_SEND: sink_valid = 1'b1;
            default: ;
        endcase
    end

    assign sink_char = char_q;
endmodule

// File: rtl/con_io_regs.sv
module con_io_regs
    import con_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          CHAR_W     = 8,
    parameter logic [15:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    output logic              kbd_ready,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_char,
    input  logic              dsp_ready
);
    localparam int RDY_BIT = DATA_W - 1;
    localparam int IE_BIT  = DATA_W - 2;
    localparam int PAD_W   = DATA_W - CHAR_W;

    reg_sel_t sel;
    logic kb_full, kb_ie, dp_rdy, dp_ie;
    logic [CHAR_W-1:0] kb_char_q;
    logic unused_wdata;

    assign unused_wdata = ^{bus_wdata[RDY_BIT], bus_wdata[IE_BIT-1:CHAR_W]};

    con_addr_dec #(
        .ADDR_W(ADDR_W), .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
        .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    con_kbd_port #(.CHAR_W(CHAR_W)) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_valid(kbd_valid),
        .src_char (kbd_char),
        .src_ready(kbd_ready),
        .data_rd  (bus_rd && sel == SEL_KDATA),
        .stat_wr  (bus_wr && sel == SEL_KSTAT),
        .ie_in    (bus_wdata[IE_BIT]),
        .full     (kb_full),
        .ie       (kb_ie),
        .char_q   (kb_char_q)
    );

    con_dsp_port #(.CHAR_W(CHAR_W)) u_dsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (bus_wr && sel == SEL_DDATA),
        .wr_char   (bus_wdata[CHAR_W-1:0]),
        .stat_wr   (bus_wr && sel == SEL_DSTAT),
        .ie_in     (bus_wdata[IE_BIT]),
        .sink_valid(dsp_valid),
        .sink_char (dsp_char),
        .sink_ready(dsp_ready),
        .rdy       (dp_rdy),
        .ie        (dp_ie)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_KSTAT: begin
                    bus_rdata[RDY_BIT] = kb_full;
                    bus_rdata[IE_BIT]  = kb_ie;
                end
                SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kb_char_q};
                SEL_DSTAT: begin
                    bus_rdata[RDY_BIT] = dp_rdy;
                    bus_rdata[IE_BIT]  = dp_ie;
                end
                SEL_DDATA: bus_rdata = {{PAD_W{1'b0}}, dsp_char};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/con_io_regs_chk.sv
module con_io_regs_chk #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 16,
    parameter int          CHAR_W     = 8,
    parameter logic [15:0] KSTAT_ADDR = 16'hFE00,
    parameter logic [15:0] KDATA_ADDR = 16'hFE02,
    parameter logic [15:0] DSTAT_ADDR = 16'hFE04,
    parameter logic [15:0] DDATA_ADDR = 16'hFE06
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              kbd_valid,
    input logic              kbd_ready,
    input logic              dsp_valid,
    input logic [CHAR_W-1:0] dsp_char,
    input logic              dsp_ready
);
    logic is_ks, is_kd, is_ds, is_dd;
    assign is_ks = bus_addr == ADDR_W'(KSTAT_ADDR);
    assign is_kd = bus_addr == ADDR_W'(KDATA_ADDR);
    assign is_ds = bus_addr == ADDR_W'(DSTAT_ADDR);
    assign is_dd = bus_addr == ADDR_W'(DDATA_ADDR);

    a_r1_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (is_ks || is_ds) |-> bus_rdata[DATA_W-3:0] == '0);

    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid && kbd_ready |=> !kbd_ready);

    a_r3_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && is_kd && !kbd_ready |=> kbd_ready);

    a_r3_data_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (is_kd || is_dd) |-> bus_rdata[DATA_W-1:CHAR_W] == '0);

    a_r5_launch: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && is_dd && !dsp_valid |=> dsp_valid && dsp_char == $past(bus_wdata[CHAR_W-1:0]));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_char));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid && dsp_ready |=> !dsp_valid);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && (is_ks || is_kd || is_ds || is_dd)) |-> bus_rdata == '0);
endmodule

bind con_io_regs con_io_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
    .KSTAT_ADDR(KSTAT_ADDR), .KDATA_ADDR(KDATA_ADDR),
    .DSTAT_ADDR(DSTAT_ADDR), .DDATA_ADDR(DDATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_ready(kbd_ready), .dsp_valid(dsp_valid),
    .dsp_char(dsp_char), .dsp_ready(dsp_ready)
);

// File: tb/con_io_regs_test.sv
module con_io_regs_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic kbd_valid = 1'b0;
    logic [7:0] kbd_char = '0;
    logic kbd_ready, dsp_valid, dsp_ready = 1'b0;
    logic [7:0] dsp_char;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    con_io_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_valid(kbd_valid), .kbd_char(kbd_char), .kbd_ready(kbd_ready),
        .dsp_valid(dsp_valid), .dsp_char(dsp_char), .dsp_ready(dsp_ready)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard for read data
    initial forever begin
        @(negedge clk);
        #1;
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                chk(bus_rdata, 16'hxxxx, "scoreboard underflow");
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end else if (rst_n) begin
            chk(bus_rdata, 16'h0000, "R9 idle bus");
        end
    end

    task automatic drive(input logic rd, input logic wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(1'b1, 1'b0, a, 16'h0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        drive(1'b0, 1'b1, a, d);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        #1;
        chk({15'b0, kbd_ready}, 16'h1, "R10 kbd_ready");
        chk({15'b0, dsp_valid}, 16'h0, "R10 dsp_valid");
        rd(16'hFE00, 16'h0000, "R10 kbd status");
        rd(16'hFE02, 16'h0000, "R10 kbd data");
        rd(16'hFE04, 16'h8000, "R10 dsp status");

        // R9 other addresses, incl. near aliases, change nothing
        rd(16'hFE01, 16'h0000, "R9 odd addr");
        rd(16'h7E00, 16'h0000, "R9 alias addr");
        wr(16'h7E06, 16'h0041);
        wr(16'hFE08, 16'hC000);
        idle();
        #1;
        chk({15'b0, dsp_valid}, 16'h0, "R9 no launch");
        rd(16'hFE04, 16'h8000, "R9 dsp status untouched");
        rd(16'hFE00, 16'h0000, "R9 kbd status untouched");

        // R8 interrupt enables; bit 15 of write ignored
        wr(16'hFE00, 16'hC000);
        wr(16'hFE04, 16'h0000);
        rd(16'hFE00, 16'h4000, "R8 kbd ie set, ready not forced");
        rd(16'hFE04, 16'h8000, "R8 dsp ie clear, ready kept");
        wr(16'hFE04, 16'h7FFF);
        rd(16'hFE04, 16'hC000, "R8 dsp ie set");
        wr(16'hFE00, 16'h8000);
        rd(16'hFE00, 16'h0000, "R8 kbd ie cleared");

        // R2 keyboard arrival
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        kbd_valid = 1; kbd_char = 8'h61;
        @(negedge clk);
        kbd_char = 8'h62;            // offered while full: must not be taken
        #1;
        chk({15'b0, kbd_ready}, 16'h0, "R2 ready low when full");
        rd(16'hFE00, 16'h8000, "R1 status full");
        kbd_valid = 0;
        rd(16'hFE02, 16'h0061, "R3 first char kept");
        idle();
        #1;
        chk({15'b0, kbd_ready}, 16'h1, "R3 ready after read");
        rd(16'hFE00, 16'h0000, "R3 status cleared");
        rd(16'hFE02, 16'h0061, "R3 read when empty");

        // R5/R6 display handshake with stall
        wr(16'hFE06, 16'hAB43);
        @(negedge clk);
        bus_wr = 0;
        #1;
        chk({15'b0, dsp_valid}, 16'h1, "R5 valid");
        chk({8'b0, dsp_char}, 16'h0043, "R5 char");
        rd(16'hFE04, 16'h4000, "R5 ready cleared");
        rd(16'hFE06, 16'h0043, "R5 data readback");
        // R7 store while busy is dropped
        wr(16'hFE06, 16'h0058);
        idle();
        #1;
        chk({8'b0, dsp_char}, 16'h0043, "R7 char unchanged");
        chk({15'b0, dsp_valid}, 16'h1, "R6 held while stalled");
        dsp_ready = 1;
        @(negedge clk);
        dsp_ready = 0;
        #1;
        chk({15'b0, dsp_valid}, 16'h0, "R6 valid dropped");
        rd(16'hFE04, 16'hC000, "R6 ready again");
        idle();
        #1;
        chk({15'b0, dsp_valid}, 16'h0, "R7 no extra send");

        // polling print loop C..K with sink always ready
        for (int i = 0; i < 9; i++) begin
            rd(16'hFE04, 16'hC000, "R4 poll ready");
            wr(16'hFE06, 16'(8'h43 + i));
            dsp_ready = 1;
            @(negedge clk);
            bus_wr = 0;
            #1;
            chk({15'b0, dsp_valid}, 16'h1, "R5 loop valid");
            chk({8'b0, dsp_char}, 16'(8'h43 + i), "R5 loop char");
            @(negedge clk);
            dsp_ready = 0;
            #1;
            chk({15'b0, dsp_valid}, 16'h0, "R6 loop release");
        end

        idle();
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule